// File: doc/BRIEF.md
# Shared Support-Vector Store with Near-Duplicate Merging

This block keeps the support vectors of a binary decision tree of SVM classifiers in one table. The tree has up to N_SVM nodes. Each row of the table holds an attribute vector and a membership bitmap, with one bit for each SVM node. A vector that several nodes use is stored once, and the bitmap records which nodes use it.

The block takes two commands. A query names one SVM and streams out every row whose membership bit for that SVM is set. A store hands in a vector during learning. The block scans all rows and finds the one with the smallest sum of absolute differences (SAD) from the new vector. It then does one of three things:
- It merges the vector into that row by setting one membership bit, if the SAD is at or below the threshold.
- It appends the vector as a new row, if the SAD is above the threshold and there is room.
- It rejects the store, if a new row is needed and the table is full.

A command is accepted when `cmd_valid` is high and `busy` is low. The block then works one row per clock and reports the result through the query stream or the store-done pulse.

Top module: `svdb_core`

## Requirements
- R1: After reset, the table is empty and `busy`, `full`, `q_valid`, `q_last` and `st_done` are all low.
- R2: A query for SVM k emits, in ascending row order, one `q_valid` cycle for each stored row whose membership bit k is set. Each such cycle carries that row's index and attributes. A query never changes the table.
- R3: A query ends with a single `q_last` cycle in which `q_valid` is low. A query for an SVM that no row uses produces only that `q_last` cycle.
- R4: A store into an empty table creates row 0. The membership bitmap of row 0 has only bit k set, and `st_merged` and `st_error` are low.
- R5: Similarity is the sum over twenty unsigned 8-bit elements of their absolute differences. Element j sits at bits [8j+7:8j] of the vector. The closest row is the one with the smallest such sum.
- R6: If the smallest SAD is strictly greater than `thresh`, the vector is written to the next free row. `st_index` reports that row, and both flags are low.
- R7: If the smallest SAD is less than or equal to `thresh`, bit k is set on the closest row. That row's attributes and the row count do not change. `st_merged` is high and `st_index` reports that row.
- R8: When two or more rows share the smallest SAD, the one with the lowest index is chosen.
- R9: `full` is high once DEPTH rows are stored. A store into a full table that finds no row within `thresh` sets `st_error` and changes nothing. A merge is still allowed while the table is full.
- R10: A command presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, taken when `busy` is low |
| cmd_store | input | 1 | 1 = store, 0 = query |
| cmd_svm | input | SVM_W | SVM node number k |
| cmd_vec | input | ELEM_W*N_ELEM | Vector to store (ignored for a query) |
| thresh | input | THR_W | Merge threshold on the SAD |
| busy | output | 1 | A command is in progress |
| full | output | 1 | All rows are in use |
| q_valid | output | 1 | A query result is on `q_index`/`q_attr` |
| q_last | output | 1 | End of the query stream |
| q_index | output | IDX_W | Row index of the query result |
| q_attr | output | ELEM_W*N_ELEM | Attributes of the query result |
| st_done | output | 1 | One-cycle pulse when a store finishes |
| st_merged | output | 1 | The store merged into an existing row |
| st_error | output | 1 | The store was rejected because the table is full |
| st_index | output | IDX_W | Row that was created or merged into |

## Verification
The assertions assume that reset is applied before the first command. They also assume that `cmd_svm` is below N_SVM and that `thresh` is stable while a store is running, so that the decision is made against one threshold. The bench changes command inputs only on falling edges. It holds `thresh` with the other store fields until the done pulse arrives. It uses SVM numbers within range, and it presents a second command during a busy query only to show that the block ignores it.

// File: rtl/svdb_pkg.sv
package svdb_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_QUERY  = 2'd1,
      ST_SEARCH = 2'd2
   } svdb_state_t;
endpackage

// File: rtl/svdb_sad.sv
module svdb_sad #(
   parameter int ELEM_W = 8,
   parameter int N_ELEM = 20,
   parameter int SAD_W  = 13
) (
   input  logic [ELEM_W*N_ELEM-1:0] vec_a,
   input  logic [ELEM_W*N_ELEM-1:0] vec_b,
   output logic [SAD_W-1:0]         sad
);
   logic [ELEM_W-1:0] diff [N_ELEM];

   for (genvar j = 0; j < N_ELEM; j++) begin : g_elem
      logic [ELEM_W-1:0] ea, eb;
      assign ea = vec_a[j*ELEM_W +: ELEM_W];
      assign eb = vec_b[j*ELEM_W +: ELEM_W];
      assign diff[j] = (ea >= eb) ? (ea - eb) : (eb - ea);
   end

   always_comb begin
      sad = '0;
      for (int j = 0; j < N_ELEM; j++) sad = sad + SAD_W'(diff[j]);
   end
endmodule

// File: rtl/svdb_minsel.sv
module svdb_minsel #(
   parameter int SAD_W = 13,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             sample_en,
   input  logic [SAD_W-1:0] cand_sad,
   input  logic [IDX_W-1:0] cand_idx,
   output logic             have,
   output logic [SAD_W-1:0] best_sad,
   output logic [IDX_W-1:0] best_idx
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have     <= 1'b0;
         best_sad <= '0;
         best_idx <= '0;
      end else if (clear) begin
         have <= 1'b0;
      end else if (sample_en && (!have || cand_sad < best_sad)) begin
         // strict compare: on a tie the earlier (lower) index is kept
         have     <= 1'b1;
         best_sad <= cand_sad;
         best_idx <= cand_idx;
      end
   end

   // R8: a later candidate with an equal SAD never displaces the kept one
   p_tie_keeps_lower_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en && !clear && have && cand_sad == best_sad) |=> $stable(best_idx));
endmodule

// File: rtl/svdb_store.sv
module svdb_store #(
   parameter int ATTR_W = 160,
   parameter int N_SVM  = 64,
   parameter int DEPTH  = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int SVM_W = $clog2(N_SVM)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [ATTR_W-1:0] rd_attr,
   output logic [N_SVM-1:0]  rd_hdr,
   input  logic              app_en,
   input  logic [ATTR_W-1:0] app_attr,
   input  logic [SVM_W-1:0]  app_svm,
   input  logic              mark_en,
   input  logic [IDX_W-1:0]  mark_idx,
   input  logic [SVM_W-1:0]  mark_svm,
   output logic [CNT_W-1:0]  count
);
   logic [ATTR_W-1:0] attr_mem [DEPTH];
   logic [N_SVM-1:0]  hdr_mem  [DEPTH];
   logic [IDX_W-1:0]  wr_slot;

   assign wr_slot = count[IDX_W-1:0];
   assign rd_attr = attr_mem[rd_idx];
   assign rd_hdr  = hdr_mem[rd_idx];

   always_ff @(posedge clk) begin
      if (app_en) attr_mem[wr_slot] <= app_attr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         for (int i = 0; i < DEPTH; i++) hdr_mem[i] <= '0;
      end else if (app_en) begin
         hdr_mem[wr_slot] <= N_SVM'(1) << app_svm;
         count            <= count + CNT_W'(1);
      end else if (mark_en) begin
         hdr_mem[mark_idx][mark_svm] <= 1'b1;
      end
   end

   // R9: the row count never passes the table depth
   p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   // R9: no append is requested when every row is in use
   p_no_append_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
      app_en |-> count != CNT_W'(DEPTH));
endmodule

// File: rtl/svdb_core.sv
module svdb_core
   import svdb_pkg::*;
#(
   parameter int ELEM_W = 8,
   parameter int N_ELEM = 20,
   parameter int N_SVM  = 64,
   parameter int DEPTH  = 16,
   parameter int THR_W  = 16,
   localparam int ATTR_W = ELEM_W * N_ELEM,
   localparam int SAD_W  = $clog2(N_ELEM * ((1 << ELEM_W) - 1) + 1),
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int SVM_W  = $clog2(N_SVM)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_store,
   input  logic [SVM_W-1:0]  cmd_svm,
   input  logic [ATTR_W-1:0] cmd_vec,
   input  logic [THR_W-1:0]  thresh,
   output logic              busy,
   output logic              full,
   output logic              q_valid,
   output logic              q_last,
   output logic [IDX_W-1:0]  q_index,
   output logic [ATTR_W-1:0] q_attr,
   output logic              st_done,
   output logic              st_merged,
   output logic              st_error,
   output logic [IDX_W-1:0]  st_index
);
   if (DEPTH < 2)   begin : g_bad_depth $error("svdb_core: DEPTH must be at least 2"); end
   if (N_SVM < 2)   begin : g_bad_svm   $error("svdb_core: N_SVM must be at least 2"); end
   if (ELEM_W < 1 || N_ELEM < 1) begin : g_bad_vec $error("svdb_core: empty vector"); end
   if (THR_W < SAD_W) begin : g_bad_thr $error("svdb_core: THR_W narrower than SAD"); end

   svdb_state_t       state;
   logic [CNT_W-1:0]  ptr, count;
   logic [SVM_W-1:0]  svm_q;
   logic [ATTR_W-1:0] vec_q, rd_attr;
   logic [N_SVM-1:0]  rd_hdr;
   logic [THR_W-1:0]  thr_q;
   logic [SAD_W-1:0]  cand_sad, best_sad;
   logic [IDX_W-1:0]  best_idx, rd_idx;
   logic              have, accept, scanning, sample_en, finish;
   logic              do_merge, do_append, do_reject;

   assign busy     = (state != ST_IDLE);
   assign full     = (count == CNT_W'(DEPTH));
   assign accept   = (state == ST_IDLE) && cmd_valid;
   assign scanning = (ptr < count);
   assign rd_idx   = ptr[IDX_W-1:0];

   always_comb begin
      sample_en = (state == ST_SEARCH) && scanning;
      finish    = (state == ST_SEARCH) && !scanning;
      do_merge  = finish && have && (32'(best_sad) <= 32'(thr_q));
      do_append = finish && !do_merge && !full;
      do_reject = finish && !do_merge && full;
   end

   svdb_sad #(.ELEM_W(ELEM_W), .N_ELEM(N_ELEM), .SAD_W(SAD_W)) u_sad (
      .vec_a(vec_q), .vec_b(rd_attr), .sad(cand_sad));

   svdb_minsel #(.SAD_W(SAD_W), .IDX_W(IDX_W)) u_min (
      .clk(clk), .rst_n(rst_n), .clear(accept), .sample_en(sample_en),
      .cand_sad(cand_sad), .cand_idx(rd_idx),
      .have(have), .best_sad(best_sad), .best_idx(best_idx));

   svdb_store #(.ATTR_W(ATTR_W), .N_SVM(N_SVM), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_attr(rd_attr), .rd_hdr(rd_hdr),
      .app_en(do_append), .app_attr(vec_q), .app_svm(svm_q),
      .mark_en(do_merge), .mark_idx(best_idx), .mark_svm(svm_q), .count(count));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         ptr       <= '0;
         svm_q     <= '0;
         vec_q     <= '0;
         thr_q     <= '0;
         q_valid   <= 1'b0;
         q_last    <= 1'b0;
         q_index   <= '0;
         q_attr    <= '0;
         st_done   <= 1'b0;
         st_merged <= 1'b0;
         st_error  <= 1'b0;
         st_index  <= '0;
      end else begin
         q_valid <= 1'b0;
         q_last  <= 1'b0;
         st_done <= 1'b0;
         unique case (state)
            ST_IDLE: if (cmd_valid) begin
               svm_q <= cmd_svm;
               vec_q <= cmd_vec;
               thr_q <= thresh;
               ptr   <= '0;
               state <= cmd_store ? ST_SEARCH : ST_QUERY;
            end
            ST_QUERY: if (scanning) begin
               q_valid <= rd_hdr[svm_q];
               q_index <= rd_idx;
               q_attr  <= rd_attr;
               ptr     <= ptr + CNT_W'(1);
            end else begin
               q_last <= 1'b1;
               state  <= ST_IDLE;
            end
            ST_SEARCH: if (scanning) begin
               ptr <= ptr + CNT_W'(1);
            end else begin
               st_done   <= 1'b1;
               st_merged <= do_merge;
               st_error  <= do_reject;
               st_index  <= do_merge ? best_idx : count[IDX_W-1:0];
               state     <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R3: the end marker never carries data
   p_last_alone_r3: assert property (@(posedge clk) disable iff (!rst_n)
      q_last |-> !q_valid);
   // R2: streaming a query result leaves the table untouched
   p_query_nowrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
      q_valid |-> $stable(count));
   // R6: a store that neither merged nor failed added exactly one row
   p_append_grows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_done && !st_merged && !st_error) |-> count == $past(count) + CNT_W'(1));
   // R7: a merge keeps the row count
   p_merge_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_done && st_merged) |-> count == $past(count));
   // R9: a rejection only happens with a full table, which stays full
   p_reject_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_done && st_error) |-> (full && $past(full)));
   // R10: accepting a command always makes the block busy on the next cycle
   p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy);
endmodule

// File: tb/sim_svdb_core.sv
module sim_svdb_core;
   localparam int DEPTH  = 4;
   localparam int ATTR_W = 160;
   localparam int IDX_W  = 2;

   typedef struct packed {
      logic [5:0]  svm;
      logic [7:0]  b;
      logic [15:0] thr;
      logic        mg;
      logic        er;
      logic [1:0]  idx;
   } step_t;

   // each stored vector has all twenty bytes equal to b, so SAD = 20*|b1-b2|
   localparam step_t STEPS [9] = '{
      '{svm:6'd3, b:8'd10,  thr:16'd0,   mg:1'b0, er:1'b0, idx:2'd0}, // R4 empty
      '{svm:6'd5, b:8'd10,  thr:16'd0,   mg:1'b1, er:1'b0, idx:2'd0}, // R7 SAD 0 == thr
      '{svm:6'd5, b:8'd50,  thr:16'd100, mg:1'b0, er:1'b0, idx:2'd1}, // R6 800 > 100
      '{svm:6'd7, b:8'd30,  thr:16'd400, mg:1'b1, er:1'b0, idx:2'd0}, // R8 tie 400/400
      '{svm:6'd9, b:8'd48,  thr:16'd40,  mg:1'b1, er:1'b0, idx:2'd1}, // R5 nearest row 1
      '{svm:6'd2, b:8'd200, thr:16'd10,  mg:1'b0, er:1'b0, idx:2'd2}, // R6
      '{svm:6'd2, b:8'd100, thr:16'd10,  mg:1'b0, er:1'b0, idx:2'd3}, // R6 fills table
      '{svm:6'd1, b:8'd150, thr:16'd10,  mg:1'b0, er:1'b1, idx:2'd0}, // R9 reject
      '{svm:6'd1, b:8'd201, thr:16'd20,  mg:1'b1, er:1'b0, idx:2'd2}  // R9 merge when full
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0, cmd_store = 1'b0;
   logic [5:0]        cmd_svm = '0;
   logic [ATTR_W-1:0] cmd_vec = '0;
   logic [15:0]       thresh = '0;
   logic              busy, full, q_valid, q_last, st_done, st_merged, st_error;
   logic [IDX_W-1:0]  q_index, st_index;
   logic [ATTR_W-1:0] q_attr;

   int checks = 0, fails = 0, cyc = 0;
   logic [63:0]       mdl_hdr [DEPTH];
   logic [ATTR_W-1:0] mdl_attr [DEPTH];
   int                mdl_cnt = 0;
   int                got_n;
   int                got_idx [8];
   logic [ATTR_W-1:0] got_attr [8];

   always #5 clk = ~clk;

   svdb_core #(.DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_store(cmd_store),
      .cmd_svm(cmd_svm), .cmd_vec(cmd_vec), .thresh(thresh),
      .busy(busy), .full(full), .q_valid(q_valid), .q_last(q_last),
      .q_index(q_index), .q_attr(q_attr), .st_done(st_done),
      .st_merged(st_merged), .st_error(st_error), .st_index(st_index));

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_store(input step_t s);
      bit seen = 0;
      @(negedge clk);
      cmd_valid = 1; cmd_store = 1; cmd_svm = s.svm;
      cmd_vec = {20{s.b}}; thresh = s.thr;
      @(negedge clk);
      cmd_valid = 0;
      for (int i = 0; i < 40; i++) begin
         if (st_done) begin seen = 1; break; end
         @(negedge clk);
      end
      chk(seen, "R6", "store done seen", seen, 1);
      chk(st_merged == s.mg, "R7", "st_merged", st_merged, s.mg);
      chk(st_error == s.er, "R9", "st_error", st_error, s.er);
      if (!s.er) chk(st_index == s.idx, "R8", "st_index", st_index, s.idx);
   endtask

   task automatic do_query(input int svm, input bit inject);
      bit ended = 0;
      got_n = 0;
      @(negedge clk);
      cmd_valid = 1; cmd_store = 0; cmd_svm = 6'(svm);
      @(negedge clk);
      if (inject) begin
         chk(busy == 1, "R10", "busy during query", busy, 1);
         cmd_store = 1; cmd_svm = 6'd11; cmd_vec = '0; thresh = 16'hFFFF;
      end else cmd_valid = 0;
      for (int i = 0; i < 40; i++) begin
         if (i == 1) cmd_valid = 0;
         if (q_valid && got_n < 8) begin
            got_idx[got_n] = int'(q_index); got_attr[got_n] = q_attr; got_n++;
         end
         if (q_last) begin ended = 1; break; end
         @(negedge clk);
      end
      cmd_valid = 0;
      chk(ended, "R3", "query end marker", ended, 1);
   endtask

   task automatic check_query(input int svm);
      int n = 0;
      do_query(svm, 0);
      for (int i = 0; i < mdl_cnt; i++) if (mdl_hdr[i][svm]) begin
         if (n < got_n) begin
            chk(got_idx[n] == i, "R2", "query index", got_idx[n], i);
            chk(got_attr[n] == mdl_attr[i], "R2", "query attributes",
                got_attr[n][7:0], mdl_attr[i][7:0]);
         end
         n++;
      end
      chk(got_n == n, "R2", "query result count", got_n, n);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!busy && !full && !q_valid && !q_last && !st_done, "R1", "idle after reset",
          {busy, full, q_valid, q_last, st_done}, 0);
      rst_n = 1;
      // R1/R3: empty table answers a query with only the end marker
      do_query(0, 0);
      chk(got_n == 0, "R3", "empty table query", got_n, 0);

      foreach (STEPS[n]) begin
         do_store(STEPS[n]);
         if (!STEPS[n].er) begin
            if (STEPS[n].mg) mdl_hdr[STEPS[n].idx][STEPS[n].svm] = 1'b1;
            else begin
               mdl_hdr[mdl_cnt] = 64'd1 << STEPS[n].svm;
               mdl_attr[mdl_cnt] = {20{STEPS[n].b}};
               mdl_cnt++;
            end
         end
         if (n == 5) chk(full == 0, "R9", "not full at three rows", full, 0);
         if (n == 6) chk(full == 1, "R9", "full at four rows", full, 1);
      end

      check_query(5);   // R2 rows 0 and 1
      check_query(2);   // R2 rows 2 and 3
      check_query(7);   // R8 tie merged into row 0, attributes kept (R7)
      check_query(1);   // R9 rejected vector absent, merge onto row 2
      check_query(63);  // R3 unused SVM
      chk(got_n == 0, "R3", "unused svm query", got_n, 0);

      // R10: a store presented during a busy query is ignored
      do_query(5, 1);
      chk(got_n == 2, "R10", "query output with injected command", got_n, 2);
      check_query(11);
      chk(got_n == 0, "R10", "ignored store left no trace", got_n, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule